// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer for a system bus. Software sets it up through four word-spaced registers: a control word, a reload value, the live 16-bit count and a write-only register that acknowledges the expiry interrupt. The count steps down once per divided tick. The tick comes from the input clock through two stages: an 8-bit prescaler that divides by P+1, then a power-of-two stage that divides by 16, 32, 64 or 128. When the count passes zero, the block loads the reload value and keeps running. That expiry event can latch a level interrupt, start a fixed-length reset request, or both, depending on two enable bits.

Software proves it is alive by writing the count register before the count runs out. A write to the count register takes effect at once, whether the timer is running or stopped. An external mask input lets a power or boot controller hold back the reset request without affecting the interrupt. The register port is a plain single-cycle write strobe with a combinational read path. No data stream crosses the block, so it has no valid/ready handshake and no back-pressure.

Top module: `prescaled_watchdog`

## Requirements
- R1: Register offsets, on `bus_addr`: control at 0x0, reload at 0x4, count at 0x8, interrupt acknowledge at 0xC. Control, reload and count read back their 16-bit contents on `bus_rdata`. A read at 0xC returns 0.
- R2: With control bit 5 (run) set, P in control bits [15:8] and S in bits [4:3], one tick occurs every (P+1)*(16<<S) clock cycles. Writing run from 0 to 1 restarts both divider stages, so the first decrement comes exactly that many cycles after the enabling write.
- R3: On each tick the count drops by one. A tick that finds the count at 0 loads the reload value instead, and this tick is the expiry event.
- R4: A write to the count register loads the written value on the next clock edge. This happens whether the timer runs or not, and the write takes priority over a tick in the same cycle.
- R5: While control bit 5 is 0, the count holds its value and is not cleared.
- R6: An expiry with control bit 2 set raises `irq`. It stays high until a write to 0xC with data bit 0 equal to 1. A write there with bit 0 equal to 0 has no effect.
- R7: An expiry with control bit 2 clear leaves `irq` low.
- R8: An expiry with control bit 0 set drives `wdt_rst_req` high for exactly 128 clock cycles, starting at the expiry edge. An expiry during an active request does not extend it.
- R9: While `rst_mask` is high, `wdt_rst_req` stays low and no request starts. `irq` behaves as if the mask were absent.
- R10: After reset, control is 0x0000, reload and count are 0xFFFF, and `irq` and `wdt_rst_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Write strobe qualifier |
| bus_we | input | 1 | Write when high together with bus_en |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| rst_mask | input | 1 | Holds back the reset request when high |
| irq | output | 1 | Latched expiry interrupt |
| wdt_rst_req | output | 1 | Reset request pulse |

## Verification
On every cycle, the bound checker confirms four things: the reset request never lasts past 128 cycles and never appears under the mask; the interrupt only rises when its enable was set, and stays up until acknowledged; a count write lands next cycle; and a stopped timer keeps its count. Other properties need directed scenarios with measured timing, and only the bench shows them. These are the exact tick period for a given prescaler and divider, the restart of the divider chain on enable, the load of the reload value at expiry, and the exact 128-cycle pulse width.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int OFS_CTRL   = 'h0;
  localparam int OFS_RELOAD = 'h4;
  localparam int OFS_COUNT  = 'h8;
  localparam int OFS_ACK    = 'hC;

  localparam int BIT_RST_EN = 0;
  localparam int BIT_IRQ_EN = 2;
  localparam int BIT_RUN    = 5;
  localparam int SEL_LSB    = 3;
  localparam int SEL_W      = 2;
  localparam int PRE_LSB    = 8;
  localparam int PRE_W      = 8;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int PRE_W        = 8,
  parameter int SEL_W        = 2,
  parameter int DIV_MIN_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre_val,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  localparam int DIV_W = DIV_MIN_LOG2 + (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_last;
  logic             pre_wrap;

  assign div_last = DIV_W'((1 << (DIV_MIN_LOG2 + int'(div_sel))) - 1);
  assign pre_wrap = (pre_q == pre_val);
  assign tick     = run && pre_wrap && (div_q == div_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      div_q <= '0;
    end else if (!run) begin
      pre_q <= '0;
      div_q <= '0;
    end else if (pre_wrap) begin
      pre_q <= '0;
      div_q <= (div_q == div_last) ? '0 : div_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  assign count  = cnt_q;
  assign expire = tick && !load && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '1;
    else if (load)    cnt_q <= load_val;
    else if (tick)    cnt_q <= (cnt_q == '0) ? reload_val : cnt_q - 1'b1;
  end
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
  parameter int LEN = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic block,
  output logic req
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;

  logic          active_q;
  logic [CW-1:0] left_q;

  assign req = active_q && !block;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      left_q   <= '0;
    end else if (active_q) begin
      if (left_q == '0) active_q <= 1'b0;
      else              left_q   <= left_q - 1'b1;
    end else if (fire && !block) begin
      active_q <= 1'b1;
      left_q   <= CW'(LEN - 1);
    end
  end
endmodule

// File: rtl/prescaled_watchdog.sv
module prescaled_watchdog
  import wdt_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 16,
  parameter int RST_LEN = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rst_mask,
  output logic              irq,
  output logic              wdt_rst_req
);
  logic [15:0]      ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count;
  logic             wr, wr_ctrl, wr_reload, wr_count, wr_ack;
  logic             tick, expire, irq_q;

  assign wr        = bus_en && bus_we;
  assign wr_ctrl   = wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_reload = wr && (bus_addr == ADDR_W'(OFS_RELOAD));
  assign wr_count  = wr && (bus_addr == ADDR_W'(OFS_COUNT));
  assign wr_ack    = wr && (bus_addr == ADDR_W'(OFS_ACK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '1;
    end else begin
      if (wr_ctrl)   ctrl_q   <= 16'(bus_wdata);
      if (wr_reload) reload_q <= CNT_W'(bus_wdata);
    end
  end

  wdt_prescale #(.PRE_W(PRE_W), .SEL_W(SEL_W), .DIV_MIN_LOG2(4)) u_prescale (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q[BIT_RUN]),
    .pre_val (ctrl_q[PRE_LSB +: PRE_W]),
    .div_sel (ctrl_q[SEL_LSB +: SEL_W]),
    .tick    (tick)
  );

  wdt_downcount #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .load       (wr_count),
    .load_val   (CNT_W'(bus_wdata)),
    .reload_val (reload_q),
    .count      (count),
    .expire     (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              irq_q <= 1'b0;
    else if (expire && ctrl_q[BIT_IRQ_EN])   irq_q <= 1'b1;
    else if (wr_ack && bus_wdata[0])         irq_q <= 1'b0;
  end
  assign irq = irq_q;

  wdt_rst_pulse #(.LEN(RST_LEN)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (expire && ctrl_q[BIT_RST_EN]),
    .block (rst_mask),
    .req   (wdt_rst_req)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_CTRL))        bus_rdata = DATA_W'(ctrl_q);
    else if (bus_addr == ADDR_W'(OFS_RELOAD)) bus_rdata = DATA_W'(reload_q);
    else if (bus_addr == ADDR_W'(OFS_COUNT))  bus_rdata = DATA_W'(count);
  end
endmodule

// File: rtl/prescaled_watchdog_chk.sv
module prescaled_watchdog_chk #(
  parameter int CNT_W   = 16,
  parameter int RST_LEN = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             irq_en,
  input logic             cnt_wr,
  input logic             ack_wr,
  input logic             ack_bit,
  input logic [CNT_W-1:0] wr_val,
  input logic [CNT_W-1:0] count,
  input logic             rst_mask,
  input logic             irq,
  input logic             rst_req
);
  localparam int HW = $clog2(RST_LEN + 2) + 1;
  logic [HW-1:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_run <= '0;
    else if (rst_req) hi_run <= hi_run + 1'b1;
    else              hi_run <= '0;
  end

  assert_pulse_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hi_run <= HW'(RST_LEN));

  assert_mask_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_mask |-> !rst_req);

  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(ack_wr && ack_bit)) |=> irq);

  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !irq_en) |=> !irq);

  assert_count_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (count == $past(wr_val)));

  assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(count));
endmodule

bind prescaled_watchdog prescaled_watchdog_chk #(.CNT_W(CNT_W), .RST_LEN(RST_LEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (ctrl_q[5]),
  .irq_en   (ctrl_q[2]),
  .cnt_wr   (wr_count),
  .ack_wr   (wr_ack),
  .ack_bit  (bus_wdata[0]),
  .wr_val   (CNT_W'(bus_wdata)),
  .count    (count),
  .rst_mask (rst_mask),
  .irq      (irq),
  .rst_req  (wdt_rst_req)
);

// File: tb/prescaled_watchdog_test.sv
`timescale 1ns/1ps
module prescaled_watchdog_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_en = 0, bus_we = 0;
  logic [3:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic        rst_mask = 0;
  logic        irq, wdt_rst_req;
  int          n_run = 0, n_fail = 0;
  bit          finished = 0;

  always #5 clk = ~clk;

  prescaled_watchdog uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_mask(rst_mask), .irq(irq), .wdt_rst_req(wdt_rst_req)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_negs(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset_state;
    logic [15:0] v;
    rd(4'h0, v); check("R10 ctrl", v, 16'h0000);
    rd(4'h4, v); check("R10 reload", v, 16'hFFFF);
    rd(4'h8, v); check("R10 count", v, 16'hFFFF);
    check("R10 irq", irq, 0);
    check("R10 rst_req", wdt_rst_req, 0);
  endtask

  task automatic t_regmap;
    logic [15:0] v;
    wr(4'h0, 16'hA3C2); rd(4'h0, v); check("R1 ctrl readback", v, 16'hA3C2);
    wr(4'h0, 16'h0000);
    wr(4'h4, 16'h1234); rd(4'h4, v); check("R1 reload readback", v, 16'h1234);
    rd(4'hC, v); check("R1 ack reads zero", v, 16'h0000);
  endtask

  task automatic t_period;
    logic [15:0] v;
    wr(4'h8, 16'd10); rd(4'h8, v); check("R4 load while stopped", v, 16'd10);
    wr(4'h0, 16'h0128);
    wait_negs(63); rd(4'h8, v); check("R2 no tick before period", v, 16'd10);
    wait_negs(1);  rd(4'h8, v); check("R2 tick at (P+1)*32", v, 16'd9);
    wr(4'h0, 16'h0000);
    wait_negs(200); rd(4'h8, v); check("R5 frozen when stopped", v, 16'd9);
    wr(4'h0, 16'h0020);
    wait_negs(15); rd(4'h8, v); check("R2 restart, before first tick", v, 16'd9);
    wait_negs(1);  rd(4'h8, v); check("R2 restart, first tick at 16", v, 16'd8);
    wr(4'h8, 16'd5); rd(4'h8, v); check("R4 load while running", v, 16'd5);
    wr(4'h0, 16'h0000);
  endtask

  task automatic t_expire_irq_rst;
    logic [15:0] v;
    wr(4'h4, 16'd2);
    wr(4'h8, 16'd0);
    wr(4'h0, 16'h0025);
    wait_negs(15); check("R6 irq low before expiry", irq, 0);
    wait_negs(1);
    rd(4'h8, v); check("R3 reload at expiry", v, 16'd2);
    check("R6 irq set on expiry", irq, 1);
    check("R8 rst_req starts", wdt_rst_req, 1);
    wr(4'h0, 16'h0005);
    wait_negs(126); check("R8 rst_req at cycle 128", wdt_rst_req, 1);
    wait_negs(1);   check("R8 rst_req ends after 128", wdt_rst_req, 0);
    check("R6 irq held", irq, 1);
    wr(4'hC, 16'h0000); check("R6 ack with bit0=0 ignored", irq, 1);
    wr(4'hC, 16'h0001); check("R6 ack clears", irq, 0);
    wr(4'h0, 16'h0000);
  endtask

  task automatic t_no_irq;
    logic [15:0] v;
    wr(4'h4, 16'd7);
    wr(4'h8, 16'd0);
    wr(4'h0, 16'h0020);
    wait_negs(16);
    rd(4'h8, v); check("R3 reload value 7", v, 16'd7);
    check("R7 irq stays low", irq, 0);
    check("R8 no rst without enable", wdt_rst_req, 0);
    wr(4'h0, 16'h0000);
  endtask

  task automatic t_mask;
    rst_mask = 1;
    wr(4'h8, 16'd0);
    wr(4'h0, 16'h0025);
    wait_negs(16);
    check("R9 irq unaffected by mask", irq, 1);
    check("R9 rst blocked", wdt_rst_req, 0);
    wr(4'h0, 16'h0000);
    wait_negs(20); check("R9 rst still blocked", wdt_rst_req, 0);
    rst_mask = 0;
    wait_negs(2); check("R9 no late request", wdt_rst_req, 0);
    wr(4'hC, 16'h0001);
  endtask

  initial begin
    #200_000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    wait_negs(3);
    rst_n = 1;
    wait_negs(1);
    t_reset_state;
    t_regmap;
    t_period;
    t_expire_irq_rst;
    t_no_irq;
    t_mask;
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule